// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

The block is a transmit DMA engine. Software keeps a circular list of two-word descriptors in memory. Each descriptor points at a buffer of frame bytes. When software pulses the start input, the engine walks the list from its current position. For each descriptor it reads the control word, then the buffer address, then streams the buffer bytes out on a byte-wide valid/ready interface. A frame may span several descriptors. After the final byte of a frame, the engine writes a status word back into the frame's first descriptor. This returns the descriptor to software and reports any faults seen by the line side during that frame.

The engine stops as soon as it reads a descriptor that still belongs to software. It remembers its position in the ring, so the next start pulse resumes at that same descriptor. The engine does not generate a CRC. It only carries a per-frame request to omit the CRC as a sideband flag on the first byte of the frame, for the downstream framer.

Top module: `txring_dma`

## Requirements
- R1: Descriptor n sits at ring base + 8*n. Its word at offset 0 is the buffer byte address and its word at offset 4 is the control word. The engine reads the control word first and the address word second.
- R2: Control bits 13:0 give the buffer's byte count. The bytes go out in rising address order from any byte alignment. The byte at address a is bits 8*a[1:0]+7 : 8*a[1:0] of the little-endian 32-bit word at a with bits 1:0 cleared. A count of zero contributes no bytes.
- R3: Control bit 15 marks the final buffer of a frame. tx_last_o is high on the final byte of that buffer and on no other byte. Bytes of buffers without the flag continue the same frame.
- R4: Control bit 31 is the ownership flag. A value of 0 means the descriptor is ready to send. Reading a value of 1 makes the engine go idle without sending any byte from that descriptor and without any memory write.
- R5: Control bit 30 is the wrap flag. The descriptor after one with this flag set is descriptor 0 at the ring base.
- R6: The engine leaves idle only on a start pulse, and busy_o is high in the cycle after that pulse. A start pulse while busy_o is high has no effect: once the engine stops, it issues no further memory access.
- R7: Control bit 16 of a frame's first descriptor is reported on tx_nocrc_o with the frame's first byte only. The flag is low on every other byte.
- R8: After a frame's final byte, the engine writes the control word of the frame's first descriptor. Bit 31 is set to 1, and the length, bit 15, bit 16, bit 30 and all other bits outside 29, 27 and 26 are left unchanged. Descriptors other than the first of the frame are not written.
- R9: In that write-back, bits 29, 27 and 26 take the values of tx_fault_i bits 0, 1 and 2 respectively. Each bit is 1 if its input was high in any cycle while the frame's buffers were being fetched or streamed, and 0 otherwise.
- R10: The descriptor index survives a stop. The next start reads the control word of the descriptor that caused the stop.
- R11: While tx_valid_o is high and tx_ready_i is low, the byte, last and no-CRC outputs hold. While mem_req_o is high and mem_ack_i is low, the address, direction and write data hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle start pulse |
| ring_base_i | input | 32 | Byte address of descriptor 0, 8-byte aligned |
| busy_o | output | 1 | High while the engine walks the ring |
| mem_req_o | output | 1 | Memory access request, held until acknowledged |
| mem_we_o | output | 1 | 1 for write, 0 for read |
| mem_addr_o | output | 32 | Byte address of the word accessed |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Access completed; read data valid in the same cycle |
| mem_rdata_i | input | 32 | Read data |
| tx_data_o | output | 8 | Frame byte |
| tx_valid_o | output | 1 | Byte valid |
| tx_ready_i | input | 1 | Byte accepted when high together with valid |
| tx_last_o | output | 1 | Final byte of the frame |
| tx_nocrc_o | output | 1 | Omit-CRC request, on the frame's first byte |
| tx_fault_i | input | 3 | Line faults: bit 0 retry limit, bit 1 transmit error, bit 2 late collision |

## Verification
The assertions take three things for granted about the environment. Memory acknowledges only an outstanding request. The ring base stays constant and 8-byte aligned while the engine is busy. The last buffer of every frame has a nonzero byte count, so that a write-back always follows a last byte. The stimulus keeps within these limits in the following ways. The memory model answers each request exactly once after a random delay. The base is fixed for the whole run. Random and directed buffers are given lengths of 1 to 40, except for one zero-length middle buffer. A software-owned stopper descriptor always closes each batch before it reaches its own first descriptor again.

// File: rtl/txr_pkg.sv
package txr_pkg;

  localparam int unsigned ADDR_W    = 32;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned LEN_W     = 14;
  localparam int unsigned FAULT_W   = 3;
  localparam int unsigned LAST_BIT  = 15;
  localparam int unsigned NOCRC_BIT = 16;
  localparam int unsigned LATE_BIT  = 26;
  localparam int unsigned TXERR_BIT = 27;
  localparam int unsigned RETRY_BIT = 29;
  localparam int unsigned WRAP_BIT  = 30;
  localparam int unsigned OWN_BIT   = 31;
  localparam logic [ADDR_W-1:0] CTRL_OFS = ADDR_W'(4);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_ADDR,
    ST_FETCH,
    ST_SEND,
    ST_WBACK
  } txr_state_e;

  // byte lane of a little-endian word
  function automatic logic [7:0] lane_byte(input logic [WORD_W-1:0] w,
                                           input logic [1:0] lane);
    return w[{lane, 3'b000} +: 8];
  endfunction

  // control word handed back to software after a frame
  function automatic logic [WORD_W-1:0] wback_word(input logic [WORD_W-1:0] ctrl,
                                                   input logic [FAULT_W-1:0] flt);
    logic [WORD_W-1:0] w;
    w            = ctrl;
    w[OWN_BIT]   = 1'b1;
    w[RETRY_BIT] = flt[0];
    w[TXERR_BIT] = flt[1];
    w[LATE_BIT]  = flt[2];
    return w;
  endfunction

endpackage

// File: rtl/txr_ring_ptr.sv
module txr_ring_ptr
  import txr_pkg::*;
#(
  parameter int unsigned IDX_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              advance_i,
  input  logic              wrap_i,
  output logic [ADDR_W-1:0] desc_addr_o
);
  localparam int unsigned SHIFT_W = IDX_W + 3;

  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (advance_i) begin
      idx_q <= wrap_i ? '0 : idx_q + 1'b1;
    end
  end

  logic [SHIFT_W-1:0] ofs_w;
  assign ofs_w       = {idx_q, 3'b000};
  assign desc_addr_o = base_i + ADDR_W'(ofs_w);
endmodule

// File: rtl/txr_buf_walker.sv
module txr_buf_walker
  import txr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              word_ld_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              take_i,
  output logic [ADDR_W-1:0] fetch_addr_o,
  output logic [7:0]        byte_o,
  output logic              last_byte_o,
  output logic              word_end_o
);
  logic [ADDR_W-1:0] ptr_q;
  logic [LEN_W-1:0]  left_q;
  logic [WORD_W-1:0] word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      left_q <= '0;
    end else if (load_i) begin
      ptr_q  <= addr_i;
      left_q <= len_i;
    end else if (take_i) begin
      ptr_q  <= ptr_q + 1'b1;
      left_q <= left_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (word_ld_i) begin
      word_q <= word_i;
    end
  end

  assign fetch_addr_o = {ptr_q[ADDR_W-1:2], 2'b00};
  assign byte_o       = lane_byte(word_q, ptr_q[1:0]);
  assign last_byte_o  = (left_q == LEN_W'(1));
  assign word_end_o   = (ptr_q[1:0] == 2'b11);
endmodule

// File: rtl/txr_fault_latch.sv
module txr_fault_latch
  import txr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_i,
  input  logic               cap_i,
  input  logic [FAULT_W-1:0] fault_i,
  output logic [FAULT_W-1:0] fault_o
);
  for (genvar b = 0; b < FAULT_W; b++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        fault_o[b] <= 1'b0;
      end else if (clr_i) begin
        fault_o[b] <= 1'b0;
      end else if (cap_i && fault_i[b]) begin
        fault_o[b] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/txring_dma.sv
module txring_dma
  import txr_pkg::*;
#(
  parameter int unsigned IDX_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [31:0]        ring_base_i,
  output logic               busy_o,
  output logic               mem_req_o,
  output logic               mem_we_o,
  output logic [31:0]        mem_addr_o,
  output logic [31:0]        mem_wdata_o,
  input  logic               mem_ack_i,
  input  logic [31:0]        mem_rdata_i,
  output logic [7:0]         tx_data_o,
  output logic               tx_valid_o,
  input  logic               tx_ready_i,
  output logic               tx_last_o,
  output logic               tx_nocrc_o,
  input  logic [2:0]         tx_fault_i
);
  txr_state_e state_q, state_d;

  logic [LEN_W-1:0]  cur_len_q;
  logic              cur_last_q;
  logic              cur_wrap_q;
  logic [WORD_W-1:0] first_ctrl_q;
  logic [ADDR_W-1:0] first_addr_q;
  logic              in_frame_q;
  logic              sof_q;

  logic [ADDR_W-1:0]  desc_addr_w;
  logic [ADDR_W-1:0]  fetch_addr_w;
  logic [7:0]         byte_w;
  logic               last_byte_w;
  logic               word_end_w;
  logic [FAULT_W-1:0] fault_w;

  // named internal events
  logic ctrl_ack_w, stop_w, ctrl_ok_w, frame_start_w;
  logic addr_ok_w, empty_buf_w, word_ok_w, take_w, buf_done_w, wb_done_w, cap_w;

  assign ctrl_ack_w    = (state_q == ST_CTRL) && mem_ack_i;
  assign stop_w        = ctrl_ack_w && mem_rdata_i[OWN_BIT];
  assign ctrl_ok_w     = ctrl_ack_w && !mem_rdata_i[OWN_BIT];
  assign frame_start_w = ctrl_ok_w && !in_frame_q;
  assign addr_ok_w     = (state_q == ST_ADDR) && mem_ack_i;
  assign empty_buf_w   = addr_ok_w && (cur_len_q == '0);
  assign word_ok_w     = (state_q == ST_FETCH) && mem_ack_i;
  assign take_w        = (state_q == ST_SEND) && tx_ready_i;
  assign buf_done_w    = empty_buf_w || (take_w && last_byte_w);
  assign wb_done_w     = (state_q == ST_WBACK) && mem_ack_i;
  assign cap_w         = (state_q inside {ST_ADDR, ST_FETCH, ST_SEND}) ||
                         ((state_q == ST_CTRL) && in_frame_q);

  txr_ring_ptr #(.IDX_W(IDX_W)) u_ptr (
    .clk        (clk),
    .rst_n      (rst_n),
    .base_i     (ring_base_i),
    .advance_i  (buf_done_w),
    .wrap_i     (cur_wrap_q),
    .desc_addr_o(desc_addr_w)
  );

  txr_buf_walker u_walk (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (addr_ok_w),
    .addr_i      (mem_rdata_i),
    .len_i       (cur_len_q),
    .word_ld_i   (word_ok_w),
    .word_i      (mem_rdata_i),
    .take_i      (take_w),
    .fetch_addr_o(fetch_addr_w),
    .byte_o      (byte_w),
    .last_byte_o (last_byte_w),
    .word_end_o  (word_end_w)
  );

  txr_fault_latch u_flt (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (frame_start_w),
    .cap_i  (cap_w),
    .fault_i(tx_fault_i),
    .fault_o(fault_w)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_CTRL;
      ST_CTRL:  if (mem_ack_i) state_d = mem_rdata_i[OWN_BIT] ? ST_IDLE : ST_ADDR;
      ST_ADDR: begin
        if (mem_ack_i) begin
          if (cur_len_q == '0) state_d = cur_last_q ? ST_WBACK : ST_CTRL;
          else                 state_d = ST_FETCH;
        end
      end
      ST_FETCH: if (mem_ack_i) state_d = ST_SEND;
      ST_SEND: begin
        if (tx_ready_i) begin
          if (last_byte_w)     state_d = cur_last_q ? ST_WBACK : ST_CTRL;
          else if (word_end_w) state_d = ST_FETCH;
        end
      end
      ST_WBACK: if (mem_ack_i) state_d = ST_CTRL;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      cur_len_q    <= '0;
      cur_last_q   <= 1'b0;
      cur_wrap_q   <= 1'b0;
      first_ctrl_q <= '0;
      first_addr_q <= '0;
      in_frame_q   <= 1'b0;
      sof_q        <= 1'b0;
    end else begin
      state_q <= state_d;
      if (ctrl_ok_w) begin
        cur_len_q  <= mem_rdata_i[LEN_W-1:0];
        cur_last_q <= mem_rdata_i[LAST_BIT];
        cur_wrap_q <= mem_rdata_i[WRAP_BIT];
      end
      if (frame_start_w) begin
        first_ctrl_q <= mem_rdata_i;
        first_addr_q <= desc_addr_w;
        in_frame_q   <= 1'b1;
        sof_q        <= 1'b1;
      end else begin
        if (wb_done_w || stop_w) in_frame_q <= 1'b0;
        if (take_w)              sof_q      <= 1'b0;
      end
    end
  end

  always_comb begin
    unique case (state_q)
      ST_CTRL:  mem_addr_o = desc_addr_w + CTRL_OFS;
      ST_ADDR:  mem_addr_o = desc_addr_w;
      ST_FETCH: mem_addr_o = fetch_addr_w;
      ST_WBACK: mem_addr_o = first_addr_q + CTRL_OFS;
      default:  mem_addr_o = '0;
    endcase
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign mem_req_o   = state_q inside {ST_CTRL, ST_ADDR, ST_FETCH, ST_WBACK};
  assign mem_we_o    = (state_q == ST_WBACK);
  assign mem_wdata_o = mem_we_o ? wback_word(first_ctrl_q, fault_w) : '0;
  assign tx_valid_o  = (state_q == ST_SEND);
  assign tx_data_o   = byte_w;
  assign tx_last_o   = tx_valid_o && cur_last_q && last_byte_w;
  assign tx_nocrc_o  = tx_valid_o && sof_q && first_ctrl_q[NOCRC_BIT];
endmodule

// File: rtl/txring_dma_chk.sv
module txring_dma_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start_i,
  input logic        busy_o,
  input logic        mem_req_o,
  input logic        mem_we_o,
  input logic [31:0] mem_addr_o,
  input logic [31:0] mem_wdata_o,
  input logic        mem_ack_i,
  input logic [7:0]  tx_data_o,
  input logic        tx_valid_o,
  input logic        tx_ready_i,
  input logic        tx_last_o,
  input logic        tx_nocrc_o
);
  assert_stream_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o) &&
                                  $stable(tx_last_o) && $stable(tx_nocrc_o));

  assert_mem_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) &&
                                $stable(mem_we_o) && $stable(mem_wdata_o));

  assert_wback_owned_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && mem_we_o |-> mem_wdata_o[31] && (mem_addr_o[2:0] == 3'b100));

  assert_wback_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req_o && mem_we_o) |-> $past(tx_valid_o && tx_ready_i && tx_last_o));

  assert_start_leaves_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o && start_i |=> busy_o);

  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !mem_req_o && !tx_valid_o);
endmodule

bind txring_dma txring_dma_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .busy_o     (busy_o),
  .mem_req_o  (mem_req_o),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o),
  .mem_wdata_o(mem_wdata_o),
  .mem_ack_i  (mem_ack_i),
  .tx_data_o  (tx_data_o),
  .tx_valid_o (tx_valid_o),
  .tx_ready_i (tx_ready_i),
  .tx_last_o  (tx_last_o),
  .tx_nocrc_o (tx_nocrc_o)
);

// File: tb/txring_dma_tb_top.sv
module txring_dma_tb_top;
  localparam int          RING = 8;
  localparam logic [31:0] BASE = 32'h100;
  localparam logic [31:0] BUFS = 32'h400;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        start = 1'b0;
  logic        busy, mem_req, mem_we, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic [7:0]  tx_data;
  logic        tx_valid, tx_last, tx_nocrc;
  logic        tx_ready = 1'b0;
  logic [2:0]  tx_fault = '0;

  txring_dma dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .ring_base_i(BASE), .busy_o(busy),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata), .tx_data_o(tx_data), .tx_valid_o(tx_valid),
    .tx_ready_i(tx_ready), .tx_last_o(tx_last), .tx_nocrc_o(tx_nocrc), .tx_fault_i(tx_fault)
  );

  // memory model and host write port
  logic [31:0] mem [0:1023];
  logic        h_we = 1'b0;
  logic [31:0] h_addr = '0, h_data = '0;
  int unsigned lat = 0;
  logic [31:0] acc_addr[$];
  bit          acc_we[$];

  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (h_we) mem[h_addr[11:2]] <= h_data;
    if (mem_req && !mem_ack) begin
      if (lat == 0) begin
        mem_ack   <= 1'b1;
        mem_rdata <= mem[mem_addr[11:2]];
        if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
        acc_addr.push_back(mem_addr);
        acc_we.push_back(mem_we);
        lat <= $urandom_range(0, 2);
      end else begin
        lat <= lat - 1;
      end
    end
  end

  bit ready_all = 1'b0;
  always @(posedge clk) tx_ready <= ready_all ? 1'b1 : ($urandom_range(0, 3) != 0);

  // stream monitor and fault injector
  logic [7:0] got_b[$];
  bit         got_l[$], got_n[$];
  bit [2:0]   fault_plan [0:255];
  bit         mon_sof = 1'b1;
  int         mon_frame = 0;

  always @(negedge clk) begin
    tx_fault = '0;
    if (rst_n && tx_valid && tx_ready) begin
      if (mon_sof) tx_fault = fault_plan[mon_frame & 255];
      got_b.push_back(tx_data);
      got_l.push_back(tx_last);
      got_n.push_back(tx_nocrc);
      mon_sof = tx_last;
      if (tx_last) mon_frame++;
    end
  end

  int total = 0, bad = 0;
  int slot = 0, plan_frame = 0;
  logic [7:0]  expq[$];
  bit          expl[$], expn[$];
  int          wb_idx[$], mid_idx[$];
  logic [31:0] wb_ctrl[$], mid_ctrl[$];
  bit [2:0]    wb_flt[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_byte(input logic [31:0] a);
    return mem[a[11:2]][{a[1:0], 3'b000} +: 8];
  endfunction

  function automatic logic [31:0] exp_wback(input logic [31:0] c, input bit [2:0] f);
    logic [31:0] w = c;
    w[31] = 1'b1; w[29] = f[0]; w[27] = f[1]; w[26] = f[2];
    return w;
  endfunction

  task automatic poke(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk); h_we = 1'b1; h_addr = a; h_data = d;
    @(negedge clk); h_we = 1'b0;
  endtask

  task automatic queue_frame(input int nb, input int l0, input int l1, input int l2,
                             input bit nocrc, input bit [2:0] flt);
    int lens[3];
    lens[0] = l0; lens[1] = l1; lens[2] = l2;
    for (int b = 0; b < nb; b++) begin
      logic [31:0] addr, ctrl;
      for (int w = 0; w < 16; w++) poke(BUFS + 32'(slot * 64 + 4 * w), $urandom);
      addr = BUFS + 32'(slot * 64) + 32'($urandom_range(0, 3));
      ctrl = 32'(lens[b]);
      if (b == nb - 1) ctrl[15] = 1'b1;
      if (b == 0) ctrl[16] = nocrc;
      if (slot == RING - 1) ctrl[30] = 1'b1;
      poke(BASE + 32'(8 * slot), addr);
      poke(BASE + 32'(8 * slot + 4), ctrl);
      for (int k = 0; k < lens[b]; k++) begin
        expq.push_back(mem_byte(addr + 32'(k)));
        expl.push_back((b == nb - 1) && (k == lens[b] - 1));
        expn.push_back(nocrc && (b == 0) && (k == 0));
      end
      if (b == 0) begin
        wb_idx.push_back(slot); wb_ctrl.push_back(ctrl); wb_flt.push_back(flt);
      end else begin
        mid_idx.push_back(slot); mid_ctrl.push_back(ctrl);
      end
      slot = (slot + 1) % RING;
    end
    fault_plan[plan_frame & 255] = flt;
    plan_frame++;
  endtask

  task automatic run_round(input bit mid_start, input string tag);
    int a0, n0, a_end, ngot, nerr_b, nerr_l, nerr_n, guard, rs;
    logic [31:0] stop_ctrl, v;
    rs = (wb_idx.size() > 0) ? wb_idx[0] : slot;
    stop_ctrl = 32'h8000_0000 | ((slot == RING - 1) ? 32'h4000_0000 : 32'h0);
    poke(BASE + 32'(8 * slot), 32'h0);
    poke(BASE + 32'(8 * slot + 4), stop_ctrl);
    a0 = acc_addr.size(); n0 = got_b.size();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy == 1'b1, "R6", {tag, " busy after start"}, busy, 1);
    if (mid_start) begin
      repeat (6) @(negedge clk);
      if (busy) begin start = 1'b1; @(negedge clk); start = 1'b0; end
    end
    guard = 0;
    while (busy && guard < 20000) begin @(negedge clk); guard++; end
    chk(guard < 20000, "R6", {tag, " engine stops"}, guard, 0);
    a_end = acc_addr.size();
    repeat (20) @(negedge clk);
    chk(!busy && acc_addr.size() == a_end, "R6", {tag, " stays stopped"},
        acc_addr.size(), a_end);
    // R1 / R10: starts at control word of the resume descriptor
    chk(acc_addr.size() > a0 && acc_addr[a0] == BASE + 32'(8 * rs + 4) && !acc_we[a0],
        "R10", {tag, " first access"}, (acc_addr.size() > a0) ? acc_addr[a0] : 0,
        BASE + 32'(8 * rs + 4));
    // R5 / R10: stops on the stopper descriptor, following wrap
    chk(acc_addr.size() > a0 && acc_addr[acc_addr.size() - 1] == BASE + 32'(8 * slot + 4),
        "R5", {tag, " stop position"}, (acc_addr.size() > 0) ? acc_addr[acc_addr.size() - 1] : 0,
        BASE + 32'(8 * slot + 4));
    ngot = got_b.size() - n0;
    chk(ngot == expq.size(), "R2", {tag, " byte count"}, ngot, expq.size());
    nerr_b = 0; nerr_l = 0; nerr_n = 0;
    for (int i = 0; i < ngot && i < expq.size(); i++) begin
      if (got_b[n0 + i] !== expq[i]) nerr_b++;
      if (got_l[n0 + i] !== expl[i]) nerr_l++;
      if (got_n[n0 + i] !== expn[i]) nerr_n++;
    end
    if (expq.size() > 0) begin
      chk(nerr_b == 0, "R2", {tag, " byte values"}, nerr_b, 0);
      chk(nerr_l == 0, "R3", {tag, " last flags"}, nerr_l, 0);
      chk(nerr_n == 0, "R7", {tag, " nocrc flags"}, nerr_n, 0);
    end
    for (int i = 0; i < wb_idx.size(); i++) begin
      v = mem[(BASE[11:2]) + 10'(2 * wb_idx[i] + 1)];
      chk(v == exp_wback(wb_ctrl[i], wb_flt[i]), (wb_flt[i] != 0) ? "R9" : "R8",
          {tag, " write-back"}, v, exp_wback(wb_ctrl[i], wb_flt[i]));
    end
    for (int i = 0; i < mid_idx.size(); i++) begin
      v = mem[(BASE[11:2]) + 10'(2 * mid_idx[i] + 1)];
      chk(v == mid_ctrl[i], "R8", {tag, " inner descriptor untouched"}, v, mid_ctrl[i]);
    end
    if (expq.size() == 0) begin
      chk(a_end - a0 == 1, "R4", {tag, " owned descriptor: single read"}, a_end - a0, 1);
    end
    expq.delete(); expl.delete(); expn.delete();
    wb_idx.delete(); wb_ctrl.delete(); wb_flt.delete();
    mid_idx.delete(); mid_ctrl.delete();
  endtask

  task automatic run_all();
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(!busy && !tx_valid && !mem_req, "R6", "reset state", {busy, tx_valid, mem_req}, 0);
    rst_n = 1'b1;
    // directed: single unaligned buffer with nocrc, then a 3-buffer frame with a zero-length middle
    queue_frame(1, 5, 0, 0, 1'b1, 3'b000);
    queue_frame(3, 3, 0, 6, 1'b0, 3'b101);
    run_round(1'b1, "A");
    // directed: descriptor still owned by software
    run_round(1'b0, "B");
    // directed: frames running across the wrap slot
    queue_frame(2, 4, 1, 0, 1'b0, 3'b010);
    queue_frame(2, 7, 2, 0, 1'b1, 3'b000);
    run_round(1'b0, "C");
    // directed: one-byte frame, last and nocrc on the same byte, no back-pressure
    ready_all = 1'b1;
    queue_frame(1, 1, 0, 0, 1'b1, 3'b111);
    run_round(1'b0, "D");
    ready_all = 1'b0;
    // random batches
    for (int r = 0; r < 12; r++) begin
      int nf = $urandom_range(1, 3);
      for (int f = 0; f < nf; f++) begin
        queue_frame($urandom_range(1, 2), $urandom_range(1, 40), $urandom_range(1, 40), 0,
                    1'($urandom_range(0, 1)), 3'($urandom_range(0, 7)));
      end
      run_round(1'($urandom_range(0, 1)), $sformatf("rnd%0d", r));
    end
  endtask

  initial begin
    bit timed_out = 1'b0;
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    if (timed_out) begin
      total++; bad++;
      $display("FAIL watchdog actual=expired expected=done");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule